// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event (signed X and Y motion plus three button states, given with a one-cycle strobe) into a five-byte packet for a serial mouse line. It stores the bytes in a small circular byte queue. A receive channel reads the queue one byte at a time.

The packet starts with a button byte. Its upper bits are fixed and its three low bits are active-low button flags. Next come the X motion byte and the Y motion byte, each clipped to a symmetric signed range. The Y axis is flipped before clipping. Two zero bytes close the packet.

A sequencer writes the packet bytes into the queue, one per clock. While it does this it reports busy, and any further event strobe is ignored. When the queue is full, new bytes are silently lost. A synchronous clear empties the queue and returns the sequencer to idle.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Every accepted event puts exactly five bytes into the queue, in this order: button byte, X byte, Y byte, 0x00, 0x00.
- R2: The button byte is 0x87 when no button is pressed. Left clears bit 2, middle clears bit 1 and right clears bit 0.
- R3: The X byte is the signed X delta clipped to the range -127..+127, in 8-bit two's complement. Values below -127 give 0x81 and values above +127 give 0x7F.
- R4: The Y byte is the negated signed Y delta, clipped to -127..+127 in 8-bit two's complement. This includes the most negative input value, which gives 0x7F.
- R5: An event is accepted only while the block is idle. After an accepted event, `busy` is high for exactly five cycles, and one byte is written into the queue in each of those cycles. An event strobe while `busy` is high adds no bytes.
- R6: The queue holds 16 bytes. A byte written while the queue holds 16 bytes is dropped, and the 16 stored bytes are unchanged.
- R7: When the queue is empty, `byteAvail` is 0 and `rdData` reads 0x00. A read strobe on an empty queue has no effect. After a read, `byteAvail` stays 1 if bytes remain.
- R8: Bytes leave the queue in the order they entered, including when the read and write positions wrap past the last entry.
- R9: A `clrAll` pulse empties the queue and returns the sequencer to idle in the next cycle. Bytes of the packet being written are discarded.
- R10: After reset, `busy` is 0, `byteAvail` is 0 and `rdData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrAll | input | 1 | Synchronous clear of queue and sequencer |
| evtValid | input | 1 | One-cycle event strobe |
| deltaX | input | DELTA_W (16) | Signed X motion |
| deltaY | input | DELTA_W (16) | Signed Y motion |
| btnLeft | input | 1 | Left button pressed |
| btnMid | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| busy | output | 1 | Packet being written; events ignored |
| byteAvail | output | 1 | Queue holds at least one byte |
| rdData | output | 8 | Head byte of the queue, 0x00 when empty |
| rdStrobe | input | 1 | Pop the head byte |

## Verification
The bench builds the block with its default parameters: 16-bit deltas and a 16-entry queue. At 16 bits the extreme inputs ±32767 and -32768 can be driven, so clipping and the overflow of negating -32768 on the Y path are both exercised. At 16 entries, four packets sent with no reads overfill the queue after the first byte of the fourth packet. Long runs with continuous reads move the queue positions around the wrap point many times.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  localparam int PKT_LEN = 5;

  typedef enum logic [1:0] {
    SEL_BTN  = 2'd0,
    SEL_X    = 2'd1,
    SEL_Y    = 2'd2,
    SEL_ZERO = 2'd3
  } byteSel_e;

  typedef struct packed {
    logic     capture;
    logic     push;
    byteSel_e sel;
  } ctrlStrb_t;

endpackage

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
  import pkt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrAll,
  input  logic      evtValid,
  output ctrlStrb_t strb,
  output logic      busy
);

  localparam int IDX_W = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  seqState_e        state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (clrAll) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (evtValid) begin
          state <= ST_RUN;
          idx   <= '0;
        end
        ST_RUN: begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && evtValid && !clrAll;
    strb.push    = (state == ST_RUN) && !clrAll;
    case (idx)
      IDX_W'(0): strb.sel = SEL_BTN;
      IDX_W'(1): strb.sel = SEL_X;
      IDX_W'(2): strb.sel = SEL_Y;
      default:   strb.sel = SEL_ZERO;
    endcase
  end

  assign busy = (state == ST_RUN);

  // R5: an accepted event makes the block busy on the next cycle
  assert_busy_after_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> busy);

  // R1: the fifth byte written is the last one of the packet
  assert_packet_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx == LAST_IDX && !clrAll) |=> !busy);

  // R9: a clear returns the sequencer to idle
  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> !busy);

endmodule

// File: rtl/pkt_path.sv
module pkt_path
  import pkt_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrAll,
  input  ctrlStrb_t          strb,
  input  logic [DELTA_W-1:0] deltaX,
  input  logic [DELTA_W-1:0] deltaY,
  input  logic               btnLeft,
  input  logic               btnMid,
  input  logic               btnRight,
  input  logic               rdStrobe,
  output logic               byteAvail,
  output logic [7:0]         rdData
);

  localparam int EXT_W = DELTA_W + 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -EXT_W'(127);
  localparam logic [7:0] BTN_IDLE = 8'h87;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  // Clipping of the motion values
  logic signed [EXT_W-1:0] xExt;
  logic signed [EXT_W-1:0] yNeg;
  logic [7:0] satX, satY, btnByte;

  always_comb begin
    xExt = {deltaX[DELTA_W-1], deltaX};
    yNeg = -$signed({deltaY[DELTA_W-1], deltaY});
    if (xExt > POS_LIM)      satX = 8'h7F;
    else if (xExt < NEG_LIM) satX = 8'h81;
    else                     satX = xExt[7:0];
    if (yNeg > POS_LIM)      satY = 8'h7F;
    else if (yNeg < NEG_LIM) satY = 8'h81;
    else                     satY = yNeg[7:0];
    btnByte = BTN_IDLE ^ {5'b0, btnLeft, btnMid, btnRight};
  end

  // Captured packet fields
  logic [7:0] capBtn, capX, capY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capBtn <= BTN_IDLE;
      capX   <= '0;
      capY   <= '0;
    end else if (strb.capture) begin
      capBtn <= btnByte;
      capX   <= satX;
      capY   <= satY;
    end
  end

  logic [7:0] pushByte;
  always_comb begin
    case (strb.sel)
      SEL_BTN: pushByte = capBtn;
      SEL_X:   pushByte = capX;
      SEL_Y:   pushByte = capY;
      default: pushByte = 8'h00;
    endcase
  end

  // Circular byte queue
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0]       slots [DEPTH];
  logic             qFull, qEmpty, doPush, doPop;

  assign qFull  = (count == CNT_FULL);
  assign qEmpty = (count == '0);
  assign doPush = strb.push && !qFull;
  assign doPop  = rdStrobe && !qEmpty && !clrAll;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PTR_W'(e)) slots[e] <= pushByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clrAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign byteAvail = !qEmpty;
  assign rdData    = qEmpty ? 8'h00 : slots[rdPtr];

  // R6: a full queue stays full while nothing is read
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && !rdStrobe && !clrAll) |=> qFull);

  // R7: an empty queue stays empty when nothing is written
  assert_empty_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!byteAvail && !strb.push && !clrAll) |=> !byteAvail);

  // R9: clear empties the queue
  assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> !byteAvail);

endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import pkt_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrAll,
  input  logic               evtValid,
  input  logic [DELTA_W-1:0] deltaX,
  input  logic [DELTA_W-1:0] deltaY,
  input  logic               btnLeft,
  input  logic               btnMid,
  input  logic               btnRight,
  output logic               busy,
  output logic               byteAvail,
  output logic [7:0]         rdData,
  input  logic               rdStrobe
);

  ctrlStrb_t strb;

  pkt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clrAll   (clrAll),
    .evtValid (evtValid),
    .strb     (strb),
    .busy     (busy)
  );

  pkt_path #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .clrAll    (clrAll),
    .strb      (strb),
    .deltaX    (deltaX),
    .deltaY    (deltaY),
    .btnLeft   (btnLeft),
    .btnMid    (btnMid),
    .btnRight  (btnRight),
    .rdStrobe  (rdStrobe),
    .byteAvail (byteAvail),
    .rdData    (rdData)
  );

endmodule

// File: tb/sim_mouse_pkt_enc.sv
module sim_mouse_pkt_enc;

  localparam int DW = 16;
  localparam int QD = 16;

  logic clk = 0, rstN = 0, clrAll = 0, evtValid = 0;
  logic [DW-1:0] deltaX = '0, deltaY = '0;
  logic btnLeft = 0, btnMid = 0, btnRight = 0;
  logic busy, byteAvail, rdStrobe;
  logic [7:0] rdData;
  logic monStrobe = 0, manStrobe = 0;
  assign rdStrobe = monStrobe | manStrobe;

  always #5 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DW), .DEPTH(QD)) u0 (
    .clk(clk), .rstN(rstN), .clrAll(clrAll), .evtValid(evtValid),
    .deltaX(deltaX), .deltaY(deltaY), .btnLeft(btnLeft), .btnMid(btnMid),
    .btnRight(btnRight), .busy(busy), .byteAvail(byteAvail),
    .rdData(rdData), .rdStrobe(rdStrobe)
  );

  int errors = 0, checks = 0, modelCnt = 0;
  bit drainOn = 0;
  int expQ[$];
  string tagQ[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int clip(int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return v & 8'hFF;
  endfunction

  task automatic expectByte(int b, string tag);
    if (!drainOn) begin
      if (modelCnt >= QD) return;  // R6: dropped when full
      modelCnt++;
    end
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic sendEvent(int dx, int dy, bit l, bit m, bit r);
    @(negedge clk);
    deltaX = dx[DW-1:0]; deltaY = dy[DW-1:0];
    btnLeft = l; btnMid = m; btnRight = r;
    evtValid = 1;
    expectByte(8'h87 ^ {l, m, r}, "R2");
    expectByte(clip(dx), "R3");
    expectByte(clip(-dy), "R4");
    expectByte(0, "R1");
    expectByte(0, "R1");
    @(negedge clk);
    evtValid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 no extra bytes", byteAvail, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    monStrobe = 0;
    if (drainOn && byteAvail) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 actual=0x%0h expected=none (unexpected byte)", rdData);
      end else begin
        string t;
        int e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rdData, e);
      end
      monStrobe = 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 actual=hung expected=finished (watchdog)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy", busy, 0);
    check("R10 byteAvail", byteAvail, 0);
    check("R10 rdData", rdData, 0);
    rstN = 1;
    @(negedge clk);
    drainOn = 1;

    // R1 R2 R3 R4 R8: many packets, queue wraps repeatedly
    sendEvent(0, 0, 0, 0, 0);
    sendEvent(5, 5, 1, 0, 0);
    sendEvent(200, -200, 0, 1, 0);
    sendEvent(-200, 200, 0, 0, 1);
    sendEvent(127, -127, 1, 1, 1);
    sendEvent(-128, -128, 1, 0, 1);
    sendEvent(32767, -32768, 0, 1, 1);
    sendEvent(-32768, 32767, 1, 1, 0);
    sendEvent(-127, 127, 0, 0, 0);
    sendEvent(-1, 1, 0, 0, 0);
    waitDrain();

    // R5: busy lasts five cycles, a strobe during busy is ignored
    begin
      int cnt = 0;
      @(negedge clk);
      deltaX = 16'd3; deltaY = 16'd4; btnLeft = 0; btnMid = 0; btnRight = 0;
      evtValid = 1;
      expectByte(8'h87, "R2"); expectByte(3, "R3"); expectByte(8'hFC, "R4");
      expectByte(0, "R1"); expectByte(0, "R1");
      @(negedge clk);
      check("R5 busy after accept", busy, 1);
      deltaX = 16'd99; deltaY = 16'd99;
      evtValid = 1;
      while (busy) begin
        cnt++;
        @(negedge clk);
        evtValid = 0;
      end
      check("R5 busy cycles", cnt, 5);
      waitDrain();
    end

    // R7: empty read returns zero and changes nothing
    drainOn = 0;
    @(negedge clk);
    manStrobe = 1;
    check("R7 empty rdData", rdData, 0);
    @(negedge clk);
    manStrobe = 0;
    check("R7 empty stays empty", byteAvail, 0);

    // R7: byteAvail remains after a read with bytes left
    modelCnt = 0;
    sendEvent(10, -10, 0, 0, 0);
    check("R7 avail before read", byteAvail, 1);
    check("R7 head byte", rdData, expQ[0]);
    void'(expQ.pop_front()); void'(tagQ.pop_front());
    manStrobe = 1;
    @(negedge clk);
    manStrobe = 0;
    check("R7 avail after read", byteAvail, 1);
    drainOn = 1;
    waitDrain();

    // R6: overfill with no reads; 16 kept, rest dropped
    drainOn = 0;
    modelCnt = 0;
    sendEvent(1, 2, 1, 0, 0);
    sendEvent(3, 4, 0, 1, 0);
    sendEvent(5, 6, 0, 0, 1);
    sendEvent(7, 8, 1, 1, 1);
    check("R6 full avail", byteAvail, 1);
    check("R6 expected kept", expQ.size(), QD);
    drainOn = 1;
    waitDrain();

    // R9: clear in the middle of a packet
    drainOn = 0;
    @(negedge clk);
    deltaX = 16'd20; deltaY = 16'd20;
    evtValid = 1;
    @(negedge clk);
    evtValid = 0;
    @(negedge clk);
    @(negedge clk);
    clrAll = 1;
    @(negedge clk);
    clrAll = 0;
    check("R9 busy after clear", busy, 0);
    check("R9 queue empty after clear", byteAvail, 0);
    check("R9 rdData after clear", rdData, 0);
    drainOn = 1;
    sendEvent(-50, 50, 0, 1, 0);
    waitDrain();

    check("R1 scoreboard empty", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule